// File: doc/BRIEF.md
# Banked Program Memory Window Mapper

This block sits between a CPU with a 16-bit address bus and a large program ROM. The ROM is larger than the CPU can see at once. The upper 32 KB of the CPU map is cut into four 8 KB windows, and each window is pointed at one 8 KB bank of the ROM. Two of the windows follow software-written bank registers. One window always shows the final bank. The remaining window shows the bank just before it. A mode bit decides whether that next-to-final bank sits in the lowest window or in the third window. The 8 KB span directly below the ROM area is routed to a work RAM.

Software changes the mapping with ordinary CPU writes into the ROM area. Only address bits 15, 14, 13 and 0 are decoded. The even slot at the bottom of the area holds a selector: it carries the mode bit and a 3-bit index. The odd slot beside it loads the bank register that the index names. The other slots in the ROM area belong to neighbouring logic, and this block ignores them. A reduced operating mode folds every ROM-area write onto the two low slots and strips the two top bits of selector writes.

The translation is purely combinational. Each write is a single-cycle strobe taken at the clock edge. There is no handshake and no back-pressure, so every strobe is accepted in the cycle it is presented. The bank count of the fitted ROM is given at run time as a power-of-two exponent. Bank numbers wrap modulo that count.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the selector mode bit, the selector index and both program bank registers are zero. With N banks fitted, the four ROM windows (0x8000, 0xA000, 0xC000, 0xE000) therefore map to banks 0, 0, N-2 and N-1.
- R2: A write is decoded from address bits 15, 14, 13 and 0 only. An address whose value ANDed with 0xE001 equals 0x8000 loads the selector from the write data: bit 6 is the mode bit and bits 2:0 are the index.
- R3: An address whose value ANDed with 0xE001 equals 0x8001 loads the data into the register named by the selector index. Index 6 is the low program register and index 7 is the high program register. Indices 0 to 5 have no effect on the program mapping.
- R4: When the mode bit is 0, window 0x8000-0x9FFF uses the low program register and window 0xC000-0xDFFF uses bank N-2. When the mode bit is 1, window 0x8000-0x9FFF uses bank N-2 and window 0xC000-0xDFFF uses the low program register.
- R5: Window 0xA000-0xBFFF always uses the high program register.
- R6: Window 0xE000-0xFFFF always uses bank N-1.
- R7: N = 2^k, where k is the rom_banks_log2 input and is limited to log2(MAX_BANKS). Every bank number is taken modulo N.
- R8: For addresses 0x8000-0xFFFF, rom_sel is 1 and phys_addr = bank*8192 + (cpu_addr & 0x1FFF). The new mapping is visible in the cycle after the write edge.
- R9: For 0x6000-0x7FFF, ram_sel is 1, rom_sel is 0 and phys_addr = cpu_addr & 0x1FFF. Below 0x6000, both selects and phys_addr are 0.
- R10: With reduced mode off, writes to slots 0xA000, 0xA001, 0xC000, 0xC001, 0xE000 or 0xE001, and writes below 0x8000, leave the mapping unchanged.
- R11: With reduced mode on, a write in 0x8000-0xFFFF is decoded from bits 15 and 0 only. An even address loads the selector with bits 7:6 cleared, so the mode bit becomes 0. An odd address loads the indexed register.
- R12: While cpu_we is 0, address and data changes leave the mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reduced_mode | input | 1 | Folds register writes onto the two low slots |
| rom_banks_log2 | input | LG_W | Exponent k of the fitted bank count N = 2^k |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Single-cycle write strobe |
| phys_addr | output | BANK_W+13 | Translated physical address |
| rom_sel | output | 1 | Address falls in the ROM area |
| ram_sel | output | 1 | Address falls in the work RAM window |

## Verification
The bench uses a 16-bank build and sweeps every bank count from 2 to 16 banks. Under each count it tries both mode settings and many register values, some of them larger than the bank count, at varying offsets in all four windows. This separates a wrong window assignment from a missing modulo wrap and from a bad offset merge. Writes to every non-mapping slot, to aliased addresses, to the unused indices 0 to 5, and with the strobe held low show that decoding looks only at the intended address bits. Reduced-mode writes through far slots show the folding and the clearing of the mode bit.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int unsigned OFFSET_W      = 13;
  localparam logic [15:0] SLOT_MASK     = 16'hE001;
  localparam logic [15:0] FOLD_MASK     = 16'h8001;
  localparam logic [15:0] SEL_SLOT      = 16'h8000;
  localparam logic [15:0] DATA_SLOT     = 16'h8001;
  localparam int unsigned SWAP_BIT      = 6;
  localparam int unsigned PRG_REG_BASE  = 6;
  localparam int unsigned PRG_REG_COUNT = 2;

  typedef struct packed {
    logic       swap;
    logic [2:0] idx;
  } sel_t;

  typedef enum logic [1:0] {
    SRC_LOW_REG  = 2'd0,
    SRC_HIGH_REG = 2'd1,
    SRC_PENULT   = 2'd2,
    SRC_FINAL    = 2'd3
  } win_src_e;

  function automatic win_src_e window_source(input int unsigned win, input logic swap);
    case (win)
      0:       return swap ? SRC_PENULT : SRC_LOW_REG;
      1:       return SRC_HIGH_REG;
      2:       return swap ? SRC_LOW_REG : SRC_PENULT;
      default: return SRC_FINAL;
    endcase
  endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reduced_mode,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic              mode_swap,
  output logic [BANK_W-1:0] bank_lo,
  output logic [BANK_W-1:0] bank_hi
);

  logic [15:0]       slot_addr;
  logic              sel_wr;
  logic              data_wr;
  sel_t              sel_d;
  sel_t              sel_q;
  logic [BANK_W-1:0] bank_q [PRG_REG_COUNT];
  logic              unused_wdata;

  assign unused_wdata = ^cpu_wdata;

  always_comb begin
    slot_addr  = reduced_mode ? (cpu_addr & FOLD_MASK) : (cpu_addr & SLOT_MASK);
    sel_wr     = cpu_we && (slot_addr == SEL_SLOT);
    data_wr    = cpu_we && (slot_addr == DATA_SLOT);
    sel_d.swap = reduced_mode ? 1'b0 : cpu_wdata[SWAP_BIT];
    sel_d.idx  = cpu_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_d;
  end

  for (genvar r = 0; r < PRG_REG_COUNT; r++) begin : g_bank
    localparam logic [2:0] REG_IDX = 3'(PRG_REG_BASE + r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[r] <= '0;
      else if (data_wr && (sel_q.idx == REG_IDX))
        bank_q[r] <= cpu_wdata[BANK_W-1:0];
    end
  end

  assign mode_swap = sel_q.swap;
  assign bank_lo   = bank_q[0];
  assign bank_hi   = bank_q[1];

  // R2: selector write lands in mode bit and index
  assert_select_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !reduced_mode) |=> (mode_swap == $past(cpu_wdata[6])));

  // R3: data slot with index 6 reaches the low program register
  assert_data_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (sel_q.idx == 3'd6)) |=> (bank_lo == $past(cpu_wdata[BANK_W-1:0])));

  // R11: folded selector writes never set the mode bit
  assert_fold_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reduced_mode && cpu_we && cpu_addr[15] && !cpu_addr[0]) |=> !mode_swap);

  // R12: no strobe, no change
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> ($stable(bank_lo) && $stable(bank_hi) && $stable(mode_swap)));

endmodule

// File: rtl/prg_map_window.sv
module prg_map_window
  import prg_map_pkg::*;
#(
  parameter  int unsigned BANK_W = 6,
  localparam int unsigned LG_W   = $clog2(BANK_W + 1),
  localparam int unsigned PHYS_W = BANK_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LG_W-1:0]   rom_banks_log2,
  input  logic [15:0]       cpu_addr,
  input  logic              mode_swap,
  input  logic [BANK_W-1:0] bank_lo,
  input  logic [BANK_W-1:0] bank_hi,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              rom_sel,
  output logic              ram_sel
);

  logic [BANK_W-1:0] bank_mask;
  logic [BANK_W-1:0] penult_bank;
  logic [BANK_W-1:0] win_bank [4];

  always_comb begin
    bank_mask = '0;
    for (int i = 0; i < BANK_W; i++)
      if (i < int'(rom_banks_log2)) bank_mask[i] = 1'b1;
    penult_bank = (bank_mask - BANK_W'(1)) & bank_mask;
  end

  for (genvar w = 0; w < 4; w++) begin : g_win
    win_src_e src;
    always_comb begin
      src = window_source(w, mode_swap);
      case (src)
        SRC_LOW_REG:  win_bank[w] = bank_lo & bank_mask;
        SRC_HIGH_REG: win_bank[w] = bank_hi & bank_mask;
        SRC_PENULT:   win_bank[w] = penult_bank;
        default:      win_bank[w] = bank_mask;
      endcase
    end
  end

  always_comb begin
    rom_sel = cpu_addr[15];
    ram_sel = (cpu_addr[15:13] == 3'b011);
    if (rom_sel)
      phys_addr = {win_bank[cpu_addr[14:13]], cpu_addr[OFFSET_W-1:0]};
    else if (ram_sel)
      phys_addr = {{BANK_W{1'b0}}, cpu_addr[OFFSET_W-1:0]};
    else
      phys_addr = '0;
  end

  // R6: top window always lands on the final bank
  assert_final_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (phys_addr[PHYS_W-1:OFFSET_W] == bank_mask));

  // R5: second window follows the high register
  assert_high_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b101) |-> (phys_addr[PHYS_W-1:OFFSET_W] == (bank_hi & bank_mask)));

  // R8: in-window offset passes straight through
  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel || ram_sel) |-> (phys_addr[OFFSET_W-1:0] == cpu_addr[OFFSET_W-1:0]));

  // R9: ROM and RAM selects never overlap
  assert_region_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}));

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter  int unsigned MAX_BANKS = 64,
  localparam int unsigned BANK_W    = $clog2(MAX_BANKS),
  localparam int unsigned LG_W      = $clog2(BANK_W + 1),
  localparam int unsigned PHYS_W    = BANK_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reduced_mode,
  input  logic [LG_W-1:0]   rom_banks_log2,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              rom_sel,
  output logic              ram_sel
);

  logic              mode_swap;
  logic [BANK_W-1:0] bank_lo;
  logic [BANK_W-1:0] bank_hi;

  prg_map_regs #(.BANK_W(BANK_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reduced_mode (reduced_mode),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_we       (cpu_we),
    .mode_swap    (mode_swap),
    .bank_lo      (bank_lo),
    .bank_hi      (bank_hi)
  );

  prg_map_window #(.BANK_W(BANK_W)) u_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .rom_banks_log2 (rom_banks_log2),
    .cpu_addr       (cpu_addr),
    .mode_swap      (mode_swap),
    .bank_lo        (bank_lo),
    .bank_hi        (bank_hi),
    .phys_addr      (phys_addr),
    .rom_sel        (rom_sel),
    .ram_sel        (ram_sel)
  );

  // R10: writes to foreign slots leave the selector alone
  assert_foreign_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !reduced_mode && cpu_addr[15] && (cpu_addr[14:13] != 2'b00)) |=>
      $stable(mode_swap));

endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

  localparam int unsigned MAXB = 16;
  localparam int unsigned BW   = 4;
  localparam int unsigned LGW  = 3;
  localparam int unsigned PW   = BW + 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reduced_mode = 1'b0;
  logic [LGW-1:0] rom_banks_log2 = 3'd4;
  logic [15:0]   cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic          cpu_we = 1'b0;
  logic [PW-1:0] phys_addr;
  logic          rom_sel;
  logic          ram_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model
  int m_swap = 0, m_idx = 0, m_lo = 0, m_hi = 0;

  always #2 clk = ~clk;

  prg_bank_mapper #(.MAX_BANKS(MAXB)) u_prg_bank_mapper (
    .clk(clk), .rst_n(rst_n), .reduced_mode(reduced_mode),
    .rom_banks_log2(rom_banks_log2), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .phys_addr(phys_addr), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] s;
    logic [7:0]  dd;
    s  = reduced_mode ? (a & 16'h8001) : (a & 16'hE001);
    dd = reduced_mode ? (d & 8'h3F) : d;
    if (s == 16'h8000) begin
      m_swap = int'(dd[6]);
      m_idx  = int'(dd[2:0]);
    end else if (s == 16'h8001) begin
      if (m_idx == 6) m_lo = int'(d);
      if (m_idx == 7) m_hi = int'(d);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic chk(input logic [15:0] a, input string req);
    int nb, bank;
    logic [PW-1:0] ep;
    logic er, eram;
    nb = 1 << ((int'(rom_banks_log2) > int'(BW)) ? BW : int'(rom_banks_log2));
    er = a[15];
    eram = (a[15:13] == 3'b011);
    case (a[14:13])
      2'd0:    bank = m_swap ? nb - 2 : m_lo;
      2'd1:    bank = m_hi;
      2'd2:    bank = m_swap ? m_lo : nb - 2;
      default: bank = nb - 1;
    endcase
    bank = bank % nb;
    if (er)        ep = PW'(bank * 8192 + int'(a[12:0]));
    else if (eram) ep = PW'(a[12:0]);
    else           ep = '0;
    cpu_addr = a;
    #1;
    checks++;
    if (phys_addr !== ep || rom_sel !== er || ram_sel !== eram) begin
      fails++;
      $display("FAIL %s addr=%h actual phys=%h rom=%b ram=%b expected phys=%h rom=%b ram=%b",
               req, a, phys_addr, rom_sel, ram_sel, ep, er, eram);
    end
  endtask

  task automatic chk_all(input int off, input string req);
    for (int w = 0; w < 4; w++)
      chk(16'h8000 | 16'(w << 13) | 16'(off & 16'h1FFF), req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_swap = 0; m_idx = 0; m_lo = 0; m_hi = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset mapping, checked while reset is held and after release
    repeat (2) @(negedge clk);
    chk_all(16'h0123, "R1");
    do_reset();
    chk_all(16'h1FFF, "R1");

    // R9: work RAM window and low space
    chk(16'h0000, "R9");
    chk(16'h5FFF, "R9");
    chk(16'h6000, "R9");
    chk(16'h7ABC, "R9");

    // R4 R5 R6 R7 R8: sweep of bank counts, modes and register values
    for (int lg = 1; lg <= 4; lg++) begin
      rom_banks_log2 = LGW'(lg);
      for (int sw = 0; sw < 2; sw++) begin
        for (int v = 0; v < 18; v++) begin
          wr(16'h8000, 8'((sw << 6) | 6));
          wr(16'h8001, 8'(v * 3 + 1));
          wr(16'h8000, 8'((sw << 6) | 7));
          wr(16'h8001, 8'(v ^ 8'h0B));
          chk_all(v * 613 + lg, "R4/R5/R6/R7/R8");
        end
      end
    end

    // R7: exponent above the bank-count limit clamps to MAX_BANKS
    rom_banks_log2 = 3'd7;
    chk_all(16'h0042, "R7");
    rom_banks_log2 = 3'd4;

    // R3: indices 0 to 5 do not touch the program mapping
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h05);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h09);
    for (int i = 0; i < 6; i++) begin
      wr(16'h8000, 8'(i));
      wr(16'h8001, 8'hFF);
      chk_all(16'h0777, "R3");
    end

    // R10: foreign slots and low-space writes are ignored
    wr(16'h8000, 8'h06);
    wr(16'hA000, 8'h47); chk_all(16'h0010, "R10");
    wr(16'hA001, 8'h0F); chk_all(16'h0011, "R10");
    wr(16'hC000, 8'h47); chk_all(16'h0012, "R10");
    wr(16'hC001, 8'h0F); chk_all(16'h0013, "R10");
    wr(16'hE000, 8'h47); chk_all(16'h0014, "R10");
    wr(16'hE001, 8'h0F); chk_all(16'h0015, "R10");
    wr(16'h6001, 8'h0F); chk_all(16'h0016, "R10");
    wr(16'h0000, 8'h47); chk_all(16'h0017, "R10");

    // R2: aliased addresses decode through bits 15,14,13,0 only
    wr(16'h9FFE, 8'h46); chk_all(16'h0020, "R2");
    wr(16'h9ABD, 8'h0D); chk_all(16'h0021, "R2");
    wr(16'h8ABC, 8'h07); wr(16'h9001, 8'h02); chk_all(16'h0022, "R2");

    // R12: strobe low ignores bus activity
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_wdata = 8'h40;
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_wdata = 8'h03;
    repeat (3) @(negedge clk);
    chk_all(16'h0030, "R12");

    // R11: reduced mode folds slots and clears the mode bit
    reduced_mode = 1'b1;
    wr(16'hE000, 8'hC6); chk_all(16'h0040, "R11");
    wr(16'hC001, 8'h09); chk_all(16'h0041, "R11");
    wr(16'hA000, 8'h47); wr(16'hE001, 8'h03); chk_all(16'h0042, "R11");
    wr(16'h6001, 8'h0E); chk_all(16'h0043, "R11");
    wr(16'hB002, 8'h06); wr(16'hF00F, 8'h0C); chk_all(16'h0044, "R11");
    reduced_mode = 1'b0;

    // R1: reset after activity restores the power-up mapping
    wr(16'h8000, 8'h46);
    do_reset();
    chk_all(16'h1555, "R1");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule